// File: doc/BRIEF.md
# NAND Page-Read Command Sequencer

This block drives the command and address phase of a raw page read from a NAND flash device during boot. After a start request it writes the read-setup opcode, the column address bytes, a selectable number of row address bytes and the read-confirm opcode onto an 8-bit bus. Each byte is qualified by a command-latch or an address-latch strobe and written with a write-enable pulse. It then waits for the device's ready/busy line to go busy and come back ready, and reports completion.

The number of row address bytes comes from a 2-bit boot code. An unprogrammed code of all zeros gives three row bytes, which suits large devices whose upper row bits need a fifth address byte. The code 2'b01 gives two row bytes for smaller parts. The two remaining codes are refused, with an error and no bus traffic at all. The data transfer that follows, error correction and timing calibration belong to other blocks.

Top module: `nand_rd_seq`

## Requirements
- R1: An accepted start writes bytes in this order: opcode 0x00, the column bytes, the row bytes, then opcode 0x30.
- R2: With cfg_i = 2'b00 the sequencer sends three row bytes, so five bytes are written with the address strobe.
- R3: With cfg_i = 2'b01 it sends two row bytes, giving four address-strobe bytes. Row bits [23:16] are not sent.
- R4: A start while idle with cfg_i = 2'b10 or 2'b11 gives done_o for one cycle with err_o = 1, one clock after the start. No write-enable pulse and no strobe occur.
- R5: Column and row bytes go least significant byte first. The column always takes two bytes: col_i[7:0], then col_i[15:8]. The row takes row_i[7:0], then row_i[15:8], then (with three row bytes) row_i[23:16].
- R6: nand_cle_o is high for both opcode bytes and nand_ale_o is high for every address byte. The two are never high together, and nand_we_n_o is low only while one of them is high.
- R7: nand_we_n_o stays low for exactly WE_LOW_CLKS clocks per byte. nand_io_o does not change while it is low, nor on the clock where it rises.
- R8: After 0x30, done_o with err_o = 0 comes only after nand_rb_n_i has gone low and then high again.
- R9: If nand_rb_n_i does not complete its low-then-high cycle within RB_TIMEOUT clocks, done_o is given with err_o = 1.
- R10: busy_o is high from an accepted start until done_o. A start while busy is ignored. err_o holds the result of the last operation and is cleared by an accepted start.
- R11: After reset, busy_o, done_o, err_o, nand_cle_o and nand_ale_o are 0 and nand_we_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, one cycle |
| cfg_i | input | 2 | Row-length boot code |
| col_i | input | COL_W | Column address |
| row_i | input | ROW_W | Row address |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error result of last operation |
| nand_io_o | output | 8 | NAND data bus |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write enable, active low |
| nand_rb_n_i | input | 1 | Ready/busy from the device, low means busy |

## Verification
The checks take for granted that nand_rb_n_i is glitch-free. They also take for granted that, once it reports ready after the busy period, it stays high until the sequencer has reported completion. The bench's device model keeps to this: it pulls the line low a few clocks after the confirm byte and releases it once, cleanly. Start pulses last one cycle and are only sent while the block is idle, except for the deliberate start issued mid-operation. The bench drives only legal values on cfg_i and the address inputs. Reserved codes are sent on purpose to test the refusal.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  localparam logic [7:0] OP_RD_SETUP   = 8'h00;
  localparam logic [7:0] OP_RD_CONFIRM = 8'h30;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_BUS, SEQ_WAIT} seq_state_t;
  typedef enum logic [1:0] {WE_IDLE, WE_SETUP, WE_LOW, WE_HOLD} we_phase_t;
  typedef enum logic [1:0] {RBW_IDLE, RBW_LOW, RBW_HIGH} rb_state_t;
endpackage

// File: rtl/nand_rd_cfg.sv
module nand_rd_cfg #(
  parameter int ROW_BYTES_MAX = 3
) (
  input  logic [1:0] code_i,
  output logic       valid_o,
  output logic [1:0] rows_o
);
  // 00 = long row (default fuse state), 01 = short row, others reserved
  always_comb begin
    case (code_i)
      2'b00:   begin valid_o = 1'b1; rows_o = 2'(ROW_BYTES_MAX);     end
      2'b01:   begin valid_o = 1'b1; rows_o = 2'(ROW_BYTES_MAX - 1); end
      default: begin valid_o = 1'b0; rows_o = 2'(ROW_BYTES_MAX);     end
    endcase
  end
endmodule

// File: rtl/nand_rd_wegen.sv
module nand_rd_wegen
  import nand_rd_pkg::*;
#(
  parameter int SETUP_CLKS = 1,
  parameter int LOW_CLKS   = 2,
  parameter int HOLD_CLKS  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  output logic we_n_o,
  output logic fin_o
);
  localparam int MAXC = (SETUP_CLKS > LOW_CLKS) ?
                        ((SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS) :
                        ((LOW_CLKS > HOLD_CLKS) ? LOW_CLKS : HOLD_CLKS);
  localparam int CW = $clog2(MAXC + 1);

  we_phase_t     phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= WE_IDLE;
      cnt    <= '0;
      we_n_o <= 1'b1;
      fin_o  <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      case (phase)
        WE_IDLE: if (go_i) begin
          phase <= WE_SETUP;
          cnt   <= '0;
        end
        WE_SETUP: if (cnt == CW'(SETUP_CLKS - 1)) begin
          phase  <= WE_LOW;
          cnt    <= '0;
          we_n_o <= 1'b0;
        end else cnt <= cnt + 1'b1;
        WE_LOW: if (cnt == CW'(LOW_CLKS - 1)) begin
          phase  <= WE_HOLD;
          cnt    <= '0;
          we_n_o <= 1'b1;
        end else cnt <= cnt + 1'b1;
        WE_HOLD: if (cnt == CW'(HOLD_CLKS - 1)) begin
          phase <= WE_IDLE;
          cnt   <= '0;
          fin_o <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: phase <= WE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_rd_rbwait.sv
module nand_rd_rbwait
  import nand_rd_pkg::*;
#(
  parameter int TIMEOUT = 4096,
  parameter int SYNC    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rb_n_i,
  input  logic arm_i,
  output logic ok_o,
  output logic tmo_o
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [SYNC-1:0] sync_q;
  logic            rb_s;
  rb_state_t       st;
  logic [TW-1:0]   tcnt;

  assign rb_s = sync_q[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC-2:0], rb_n_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RBW_IDLE;
      tcnt  <= '0;
      ok_o  <= 1'b0;
      tmo_o <= 1'b0;
    end else begin
      ok_o  <= 1'b0;
      tmo_o <= 1'b0;
      case (st)
        RBW_IDLE: if (arm_i) begin
          st   <= RBW_LOW;
          tcnt <= '0;
        end
        RBW_LOW, RBW_HIGH: begin
          if (st == RBW_HIGH && rb_s) begin
            ok_o <= 1'b1;
            st   <= RBW_IDLE;
          end else if (tcnt == TW'(TIMEOUT - 1)) begin
            tmo_o <= 1'b1;
            st    <= RBW_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
            if (st == RBW_LOW && !rb_s) st <= RBW_HIGH;
          end
        end
        default: st <= RBW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
  import nand_rd_pkg::*;
#(
  parameter int COL_W       = 16,
  parameter int ROW_W       = 24,
  parameter int SETUP_CLKS  = 1,
  parameter int WE_LOW_CLKS = 2,
  parameter int HOLD_CLKS   = 1,
  parameter int RB_TIMEOUT  = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       cfg_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [7:0]       nand_io_o,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_n_o,
  input  logic             nand_rb_n_i
);
  localparam int COL_BYTES     = COL_W / 8;
  localparam int ROW_BYTES_MAX = ROW_W / 8;
  localparam int ADDR_BYTES    = COL_BYTES + ROW_BYTES_MAX;
  localparam int IDX_W         = $clog2(ADDR_BYTES + 2);

  seq_state_t       state;
  logic [IDX_W-1:0] idx, last_idx, nxt_idx;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic             go, arm, fin, rb_ok, rb_tmo;
  logic             cfg_valid;
  logic [1:0]       cfg_rows;
  logic [7:0]       addr_byte [ADDR_BYTES];
  logic [ROW_W+COL_W-1:0] addr_flat;

  assign addr_flat = {row_q, col_q};
  assign nxt_idx   = idx + 1'b1;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign addr_byte[g] = addr_flat[8*g +: 8];
  end

  nand_rd_cfg #(.ROW_BYTES_MAX(ROW_BYTES_MAX)) u_cfg (
    .code_i (cfg_i),
    .valid_o(cfg_valid),
    .rows_o (cfg_rows)
  );

  nand_rd_wegen #(
    .SETUP_CLKS(SETUP_CLKS), .LOW_CLKS(WE_LOW_CLKS), .HOLD_CLKS(HOLD_CLKS)
  ) u_we (
    .clk(clk), .rst(rst), .go_i(go), .we_n_o(nand_we_n_o), .fin_o(fin)
  );

  nand_rd_rbwait #(.TIMEOUT(RB_TIMEOUT)) u_rb (
    .clk(clk), .rst(rst), .rb_n_i(nand_rb_n_i), .arm_i(arm),
    .ok_o(rb_ok), .tmo_o(rb_tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      idx        <= '0;
      last_idx   <= '0;
      col_q      <= '0;
      row_q      <= '0;
      go         <= 1'b0;
      arm        <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      nand_io_o  <= '0;
      nand_cle_o <= 1'b0;
      nand_ale_o <= 1'b0;
    end else begin
      go     <= 1'b0;
      arm    <= 1'b0;
      done_o <= 1'b0;
      case (state)
        SEQ_IDLE: if (start_i) begin
          if (cfg_valid) begin
            col_q      <= col_i;
            row_q      <= row_i;
            last_idx   <= IDX_W'(COL_BYTES + 1) + IDX_W'(cfg_rows);
            idx        <= '0;
            nand_io_o  <= OP_RD_SETUP;
            nand_cle_o <= 1'b1;
            nand_ale_o <= 1'b0;
            go         <= 1'b1;
            busy_o     <= 1'b1;
            err_o      <= 1'b0;
            state      <= SEQ_BUS;
          end else begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end
        end
        SEQ_BUS: if (fin) begin
          if (idx == last_idx) begin
            nand_cle_o <= 1'b0;
            nand_ale_o <= 1'b0;
            arm        <= 1'b1;
            state      <= SEQ_WAIT;
          end else begin
            idx <= nxt_idx;
            go  <= 1'b1;
            if (nxt_idx == last_idx) begin
              nand_io_o  <= OP_RD_CONFIRM;
              nand_cle_o <= 1'b1;
              nand_ale_o <= 1'b0;
            end else begin
              nand_io_o  <= addr_byte[idx];
              nand_cle_o <= 1'b0;
              nand_ale_o <= 1'b1;
            end
          end
        end
        SEQ_WAIT: if (rb_ok || rb_tmo) begin
          done_o <= 1'b1;
          err_o  <= rb_tmo;
          busy_o <= 1'b0;
          state  <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_rd_seq_chk.sv
module nand_rd_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic [1:0] cfg_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic [7:0] nand_io_o,
  input logic       nand_cle_o,
  input logic       nand_ale_o,
  input logic       nand_we_n_o,
  input logic       nand_rb_n_i
);
  p_cle_ale_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle_o && nand_ale_o));

  p_we_qual_r6: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n_o |-> (nand_cle_o || nand_ale_o));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (nand_we_n_o && !nand_cle_o && !nand_ale_o));

  p_reject_r4: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && cfg_i[1]) |=> (done_o && err_o && !busy_o));

  p_io_hold_low_r7: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n_o && $past(!nand_we_n_o)) |-> $stable(nand_io_o));

  p_io_hold_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_we_n_o) |-> $stable(nand_io_o));

  p_done_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && busy_o == 1'b0 && !err_o) |-> nand_rb_n_i);

  p_busy_end_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
endmodule

bind nand_rd_seq nand_rd_seq_chk u_chk (.*);

// File: tb/tb_nand_rd_seq.sv
module tb_nand_rd_seq;
  localparam int WE_LOW  = 3;
  localparam int TIMEOUT = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  cfg_i = 2'b00;
  logic [15:0] col_i = '0;
  logic [23:0] row_i = '0;
  logic        busy_o, done_o, err_o;
  logic [7:0]  nand_io_o;
  logic        nand_cle_o, nand_ale_o, nand_we_n_o;
  logic        nand_rb_n_i;

  always #10 clk = ~clk;

  nand_rd_seq #(.WE_LOW_CLKS(WE_LOW), .RB_TIMEOUT(TIMEOUT)) dut (.*);

  int n_run = 0, n_fail = 0;
  logic [9:0] exp_q [$];
  logic exp_err_v = 1'b0;
  int   done_cnt = 0, ale_cnt = 0, kick_cnt = 0, rb_done_cnt = 0, rb_base = 0;
  logic rb_respond = 1'b1;
  bit   finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor
  logic       prev_we = 1'b1;
  logic [7:0] fall_io = '0;
  int         low_cnt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!nand_we_n_o) low_cnt++;
      if (prev_we && !nand_we_n_o) fall_io = nand_io_o;
      if (!prev_we && nand_we_n_o) begin
        chk(low_cnt == WE_LOW, "R7 we low width", low_cnt, WE_LOW);
        chk(nand_io_o == fall_io, "R7 data stable", nand_io_o, fall_io);
        if (nand_ale_o) ale_cnt++;
        if (exp_q.size() == 0) chk(0, "R4 R10 unexpected write", {nand_cle_o, nand_ale_o, nand_io_o}, 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk({nand_cle_o, nand_ale_o, nand_io_o} == e, "R1 R5 R6 byte",
              {nand_cle_o, nand_ale_o, nand_io_o}, e);
        end
        if (nand_cle_o && nand_io_o == 8'h30) kick_cnt++;
        low_cnt = 0;
      end
      if (done_o) begin
        done_cnt++;
        chk(err_o == exp_err_v, "R4 R9 err at done", err_o, exp_err_v);
        chk(exp_q.size() == 0, "R1 all bytes before done", exp_q.size(), 0);
        if (!exp_err_v && exp_q.size() == 0 && kick_cnt > 0)
          chk(rb_done_cnt == rb_base + 1, "R8 done after ready cycle", rb_done_cnt, rb_base + 1);
      end
      prev_we = nand_we_n_o;
    end
  end

  // device ready/busy model
  initial begin
    int served = 0;
    nand_rb_n_i = 1'b1;
    forever begin
      @(negedge clk);
      if (kick_cnt != served) begin
        served = kick_cnt;
        if (rb_respond) begin
          repeat (3) @(negedge clk);
          nand_rb_n_i = 1'b0;
          repeat (15) @(negedge clk);
          nand_rb_n_i = 1'b1;
          rb_done_cnt++;
        end
      end
    end
  end

  task automatic run_op(input logic [1:0] cfg, input logic [15:0] col, input logic [23:0] row,
                        input bit respond, input bit exp_err, input int exp_ale, input bit poke);
    int d0, a0, guard;
    bit valid;
    valid = (cfg[1] == 1'b0);
    if (valid) begin
      exp_q.push_back({2'b10, 8'h00});
      exp_q.push_back({2'b01, col[7:0]});
      exp_q.push_back({2'b01, col[15:8]});
      exp_q.push_back({2'b01, row[7:0]});
      exp_q.push_back({2'b01, row[15:8]});
      if (cfg == 2'b00) exp_q.push_back({2'b01, row[23:16]});
      exp_q.push_back({2'b10, 8'h30});
    end
    exp_err_v  = exp_err;
    rb_respond = respond;
    rb_base    = rb_done_cnt;
    d0 = done_cnt;
    a0 = ale_cnt;
    @(negedge clk);
    cfg_i = cfg; col_i = col; row_i = row; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (valid) begin
      @(negedge clk);
      chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
      if (poke) begin
        repeat (10) @(negedge clk);
        cfg_i = 2'b01; col_i = 16'h5555; row_i = 24'h555555; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end
    end else begin
      chk(done_o == 1'b1, "R4 reject done next cycle", done_o, 1);
      chk(busy_o == 1'b0, "R4 reject stays idle", busy_o, 0);
    end
    guard = 0;
    while (done_cnt == d0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(done_cnt == d0 + 1, "R8 R9 done seen", done_cnt - d0, 1);
    if (cfg == 2'b00) chk(ale_cnt - a0 == exp_ale, "R2 five address bytes", ale_cnt - a0, exp_ale);
    else if (cfg == 2'b01) chk(ale_cnt - a0 == exp_ale, "R3 four address bytes", ale_cnt - a0, exp_ale);
    else chk(ale_cnt - a0 == 0, "R4 no address bytes", ale_cnt - a0, 0);
    repeat (4) @(negedge clk);
    chk(busy_o == 1'b0 && nand_we_n_o && !nand_cle_o && !nand_ale_o, "R10 idle after done",
        {busy_o, nand_we_n_o, nand_cle_o, nand_ale_o}, 4'b0100);
    chk(err_o == exp_err, "R10 err holds result", err_o, exp_err);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o, "R11 reset status", {busy_o, done_o, err_o}, 0);
    chk(nand_we_n_o && !nand_cle_o && !nand_ale_o, "R11 reset bus",
        {nand_we_n_o, nand_cle_o, nand_ale_o}, 3'b100);
    run_op(2'b00, 16'hA5C3, 24'h123456, 1, 0, 5, 0);
    run_op(2'b01, 16'h0F0E, 24'hABCDEF, 1, 0, 4, 0);
    run_op(2'b10, 16'h1111, 24'h222222, 1, 1, 0, 0);
    run_op(2'b11, 16'h3333, 24'h444444, 1, 1, 0, 0);
    run_op(2'b00, 16'h8001, 24'h00FF7E, 0, 1, 5, 0);
    run_op(2'b00, 16'hFFFF, 24'hFFFFFF, 1, 0, 5, 1);
    run_op(2'b01, 16'h0000, 24'h000000, 1, 0, 4, 0);
    summary();
  end
endmodule